// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block converts a 64-bit virtual address into a real address. It walks a hierarchy of translation tables held in memory. A walk begins from one of three control elements (primary, secondary or home), chosen from the requested address-space mode and the kind of access. The control element names the type of the topmost table. The walker then indexes up to four upper tables (region tables and a segment table) with fields taken from the virtual address, and finally indexes a page table. Each entry is fetched with one 64-bit read on a simple request/response port. Only one read is outstanding at a time, and the port can take any number of cycles to answer.

The walk can end in one of two ways. It can succeed, giving a real address and a write-permitted flag. Or it can fail with a typed fault code and a translation-exception word that records the page and the space that was used. When translation is switched off, or when the control element marks a real space, the virtual address passes through unchanged and no memory is read. The walker takes one request at a time. It holds busy high until it presents a single-cycle done.

Top module: `ptw_walker`

## Requirements
- R1: With `xlate_en_i` low, the walk completes with `real_addr_o` equal to the virtual address, `wr_ok_o`=1 and `fault_o`=0, and issues no memory read.
- R2: With translation on and bit 5 (real-space) of the selected control element set, the result is the same identity map as in R1, with no memory read.
- R3: Control element and upper-table entries hold a table type in bits [3:2] (0 segment, 1 third region, 2 second region, 3 first region) and a table origin in bits [63:12]. The first read goes to origin + ((va >> s) & 0x3FF8), where s is 50, 39, 28 or 17 for type 3, 2, 1 or 0. Each accepted entry descends one type. A walk with top type t makes exactly t+2 reads. On success `real_addr_o` = {PTE[63:12], va[11:0]}.
- R4: The read after a segment-table entry goes to the page table at {entry[63:11], 11'b0} + ((va >> 9) & 0x7F8).
- R5: An upper entry with bit 5 set ends the walk with fault code 1 (segment translation). A page-table entry with bit 10 set ends it with fault code 2 (page translation). No further read is issued.
- R6: An upper entry read from a table of type t whose type field is not t ends the walk with fault code 3 (translation specification).
- R7: Before any read, top type 2 with va & 0xFFE0000000000000 nonzero, type 1 with va & 0xFFFFFC0000000000 nonzero, or type 0 with va & 0xFFFFFFFF80000000 nonzero gives fault code 3 and no read. Type 3 has no range limit.
- R8: A page-table entry with bit 9 set (read-only) gives `wr_ok_o`=0 for reads and fetches. A write access (`acc_i`=1) to such a page ends with fault code 4 (protection).
- R9: On a fault, `exc_word_o` = {va[63:12], 12'b0} OR the space code (1 primary, 2 secondary, 3 home), with bit 2 also set for a protection fault. On a fault `wr_ok_o` is 0.
- R10: `space_i` 1 selects the primary element, 2 the secondary and 3 the home element; 0 acts as primary. In secondary mode an instruction fetch (`acc_i`=2) uses the primary element and space code 1, while data accesses use the secondary element.
- R11: `start` is taken only when `busy_o` is low. `busy_o` stays high until the result is presented. `done_o` is a one-cycle pulse with `busy_o` low. `mem_req_o` is a one-cycle pulse issued only while busy. A `start` raised while busy has no effect on the walk in progress.
- R12: Faults are ranked: on an upper entry, the invalid bit is tested before the type field. On a page-table entry, the invalid bit is tested before protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when idle) |
| vaddr_i | input | 64 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| space_i | input | 2 | Address-space mode: 1 primary, 2 secondary, 3 home |
| xlate_en_i | input | 1 | Translation enable |
| ce_pri_i | input | 64 | Primary control element |
| ce_sec_i | input | 64 | Secondary control element |
| ce_home_i | input | 64 | Home control element |
| mem_req_o | output | 1 | Table read request pulse |
| mem_addr_o | output | 64 | Table entry address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid for one cycle |
| real_addr_o | output | 64 | Translated real address |
| wr_ok_o | output | 1 | Write permitted |
| fault_o | output | 3 | 0 none, 1 segment, 2 page, 3 specification, 4 protection |
| exc_word_o | output | 64 | Translation-exception word |

## Verification
Two pairs of events can fall in the same cycle. The first pair is result delivery and request acceptance: every walk in the bench is started on the very sample at which the previous `done_o` is seen. Each result must then come from the new inputs and be delivered exactly once. The second pair is two fault conditions on one entry. The bench builds entries that are both invalid and mistyped, and page entries that are both invalid and read-only under a write. It judges the reported code against the ranking in R12. A stray `start` pulse is also injected mid-walk, and the address that completes must be the one first presented.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    localparam int VA_W      = 64;
    localparam int PG_LSB    = 12;   // page offset width
    localparam int SEG_ORG_L = 11;   // low bit of page-table origin in a segment entry
    localparam int TYPE_LO   = 2;
    localparam int TYPE_HI   = 3;
    localparam int ENT_INV   = 5;    // invalid bit of an upper entry
    localparam int CE_REAL   = 5;    // real-space bit of a control element
    localparam int PTE_RO    = 9;
    localparam int PTE_INV   = 10;

    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;
    localparam logic [1:0] SP_PRI    = 2'd1;
    localparam logic [1:0] SP_SEC    = 2'd2;
    localparam logic [1:0] SP_HOME   = 2'd3;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_SEG  = 3'd1,
        FLT_PAGE = 3'd2,
        FLT_SPEC = 3'd3,
        FLT_PROT = 3'd4
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TOP,
        ST_REQ,
        ST_WAIT
    } st_e;

    // byte offset of the entry in an upper table of the given type
    function automatic logic [VA_W-1:0] upper_offset(input logic [VA_W-1:0] va,
                                                     input logic [1:0] tbl);
        logic [VA_W-1:0] sh;
        case (tbl)
            2'd3:    sh = va >> 50;
            2'd2:    sh = va >> 39;
            2'd1:    sh = va >> 28;
            default: sh = va >> 17;
        endcase
        return sh & 64'h3FF8;
    endfunction

    function automatic logic [VA_W-1:0] page_offset(input logic [VA_W-1:0] va);
        return (va >> 9) & 64'h07F8;
    endfunction

    // address too wide for the topmost table type
    function automatic logic range_bad(input logic [VA_W-1:0] va, input logic [1:0] top);
        case (top)
            2'd2:    return |(va & 64'hFFE0_0000_0000_0000);
            2'd1:    return |(va & 64'hFFFF_FC00_0000_0000);
            2'd0:    return |(va & 64'hFFFF_FFFF_8000_0000);
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ptw_space_sel.sv
`timescale 1ns/1ps
module ptw_space_sel
    import ptw_pkg::*;
(
    input  logic [1:0]      space_i,
    input  logic [1:0]      acc_i,
    input  logic [VA_W-1:0] ce_pri_i,
    input  logic [VA_W-1:0] ce_sec_i,
    input  logic [VA_W-1:0] ce_home_i,
    output logic [VA_W-1:0] ce_o,
    output logic [1:0]      code_o
);
    always_comb begin
        if (space_i == SP_SEC && acc_i == ACC_FETCH) begin
            code_o = SP_PRI;
        end else if (space_i == 2'd0) begin
            code_o = SP_PRI;
        end else begin
            code_o = space_i;
        end
        case (code_o)
            SP_SEC:  ce_o = ce_sec_i;
            SP_HOME: ce_o = ce_home_i;
            default: ce_o = ce_pri_i;
        endcase
    end
endmodule

// File: rtl/ptw_index.sv
`timescale 1ns/1ps
module ptw_index
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] va_i,
    input  logic [VA_W-1:0] desc_i,
    input  logic [1:0]      tbl_i,
    input  logic            page_i,
    output logic [VA_W-1:0] addr_o
);
    logic [VA_W-1:0] up_org;
    logic [VA_W-1:0] pt_org;
    logic            unused_low;

    assign up_org     = {desc_i[VA_W-1:PG_LSB], {PG_LSB{1'b0}}};
    assign pt_org     = {desc_i[VA_W-1:SEG_ORG_L], {SEG_ORG_L{1'b0}}};
    assign unused_low = ^desc_i[SEG_ORG_L-1:0];

    always_comb begin
        if (page_i) addr_o = pt_org + page_offset(va_i);
        else        addr_o = up_org + upper_offset(va_i, tbl_i);
    end
endmodule

// File: rtl/ptw_entry_chk.sv
`timescale 1ns/1ps
module ptw_entry_chk
    import ptw_pkg::*;
(
    input  logic       page_i,
    input  logic [1:0] tbl_i,
    input  logic       wr_i,
    input  logic       ent_inv_i,
    input  logic [1:0] ent_type_i,
    input  logic       pte_inv_i,
    input  logic       pte_ro_i,
    output flt_e       flt_o,
    output logic       ro_o
);
    assign ro_o = pte_ro_i;

    always_comb begin
        flt_o = FLT_NONE;
        if (page_i) begin
            if (pte_inv_i)               flt_o = FLT_PAGE;
            else if (pte_ro_i && wr_i)   flt_o = FLT_PROT;
        end else begin
            if (ent_inv_i)               flt_o = FLT_SEG;
            else if (ent_type_i != tbl_i) flt_o = FLT_SPEC;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] vaddr_i,
    input  logic [1:0]  acc_i,
    input  logic [1:0]  space_i,
    input  logic        xlate_en_i,
    input  logic [63:0] ce_pri_i,
    input  logic [63:0] ce_sec_i,
    input  logic [63:0] ce_home_i,
    output logic        mem_req_o,
    output logic [63:0] mem_addr_o,
    input  logic        mem_valid_i,
    input  logic [63:0] mem_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [63:0] real_addr_o,
    output logic        wr_ok_o,
    output logic [2:0]  fault_o,
    output logic [63:0] exc_word_o
);
    st_e             state_q, state_d;
    logic [VA_W-1:0] va_q, desc_q;
    logic [1:0]      acc_q, code_q, tbl_q, tbl_d;
    logic            page_q, page_d, xoff_q, load_desc;

    logic [VA_W-1:0] sel_ce;
    logic [1:0]      sel_code;
    logic [VA_W-1:0] tbl_addr;
    flt_e            ent_flt;
    logic            ent_ro;

    logic            fin, fin_wr;
    flt_e            fin_flt;
    logic [VA_W-1:0] fin_real;

    logic            done_q, wr_q;
    flt_e            flt_q;
    logic [VA_W-1:0] real_q, exc_q;
    logic            unused_bits;

    ptw_space_sel u_sel (
        .space_i   (space_i),
        .acc_i     (acc_i),
        .ce_pri_i  (ce_pri_i),
        .ce_sec_i  (ce_sec_i),
        .ce_home_i (ce_home_i),
        .ce_o      (sel_ce),
        .code_o    (sel_code)
    );

    ptw_index u_idx (
        .va_i   (va_q),
        .desc_i (desc_q),
        .tbl_i  (tbl_q),
        .page_i (page_q),
        .addr_o (tbl_addr)
    );

    ptw_entry_chk u_ent (
        .page_i     (page_q),
        .tbl_i      (tbl_q),
        .wr_i       (acc_q == ACC_WRITE),
        .ent_inv_i  (mem_rdata_i[ENT_INV]),
        .ent_type_i (mem_rdata_i[TYPE_HI:TYPE_LO]),
        .pte_inv_i  (mem_rdata_i[PTE_INV]),
        .pte_ro_i   (mem_rdata_i[PTE_RO]),
        .flt_o      (ent_flt),
        .ro_o       (ent_ro)
    );

    assign unused_bits = ^{mem_rdata_i[1:0], mem_rdata_i[4], mem_rdata_i[8:6],
                           mem_rdata_i[11], desc_q[1:0], desc_q[4], desc_q[11:6]};

    always_comb begin
        state_d   = state_q;
        tbl_d     = tbl_q;
        page_d    = page_q;
        load_desc = 1'b0;
        fin       = 1'b0;
        fin_flt   = FLT_NONE;
        fin_real  = va_q;
        fin_wr    = 1'b1;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_TOP;
            ST_TOP: begin
                if (xoff_q || desc_q[CE_REAL]) begin
                    fin = 1'b1;
                end else if (range_bad(va_q, desc_q[TYPE_HI:TYPE_LO])) begin
                    fin     = 1'b1;
                    fin_flt = FLT_SPEC;
                end else begin
                    state_d = ST_REQ;
                    tbl_d   = desc_q[TYPE_HI:TYPE_LO];
                    page_d  = 1'b0;
                end
            end
            ST_REQ: state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_valid_i) begin
                    if (ent_flt != FLT_NONE) begin
                        fin     = 1'b1;
                        fin_flt = ent_flt;
                    end else if (page_q) begin
                        fin      = 1'b1;
                        fin_real = {mem_rdata_i[VA_W-1:PG_LSB], va_q[PG_LSB-1:0]};
                        fin_wr   = !ent_ro;
                    end else begin
                        load_desc = 1'b1;
                        state_d   = ST_REQ;
                        if (tbl_q == 2'd0) page_d = 1'b1;
                        else               tbl_d  = tbl_q - 2'd1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (fin_flt != FLT_NONE) begin
            fin_real = '0;
            fin_wr   = 1'b0;
        end
        if (fin) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            desc_q  <= '0;
            acc_q   <= '0;
            code_q  <= SP_PRI;
            tbl_q   <= '0;
            page_q  <= 1'b0;
            xoff_q  <= 1'b0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            flt_q   <= FLT_NONE;
            real_q  <= '0;
            exc_q   <= '0;
        end else begin
            state_q <= state_d;
            tbl_q   <= tbl_d;
            page_q  <= page_d;
            done_q  <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                va_q   <= vaddr_i;
                acc_q  <= acc_i;
                code_q <= sel_code;
                desc_q <= sel_ce;
                xoff_q <= !xlate_en_i;
            end
            if (load_desc) desc_q <= mem_rdata_i;
            if (fin) begin
                done_q <= 1'b1;
                flt_q  <= fin_flt;
                real_q <= fin_real;
                wr_q   <= fin_wr;
                if (fin_flt != FLT_NONE)
                    exc_q <= {va_q[VA_W-1:PG_LSB], {(PG_LSB-3){1'b0}},
                              fin_flt == FLT_PROT, 1'b0, 1'b0} | {62'd0, code_q};
                else
                    exc_q <= '0;
            end
        end
    end

    assign mem_req_o   = (state_q == ST_REQ);
    assign mem_addr_o  = tbl_addr;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign real_addr_o = real_q;
    assign wr_ok_o     = wr_q;
    assign fault_o     = flt_q;
    assign exc_word_o  = exc_q;
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy_o,
    input logic        done_o,
    input logic        mem_req_o,
    input logic        wr_ok_o,
    input logic [2:0]  fault_o,
    input logic [63:0] exc_word_o
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    assert_req_busy_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> busy_o);
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);
    assert_start_taken_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_o) |=> busy_o);
    assert_prot_bit_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && fault_o == 3'd4) |-> exc_word_o[2]);
    assert_space_code_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && fault_o != 3'd0) |-> (exc_word_o[1:0] != 2'd0));
    assert_fault_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && fault_o != 3'd0) |-> !wr_ok_o);
endmodule

bind ptw_walker ptw_walker_chk u_asrt (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_req_o  (mem_req_o),
    .wr_ok_o    (wr_ok_o),
    .fault_o    (fault_o),
    .exc_word_o (exc_word_o)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] vaddr_i = '0;
    logic [1:0]  acc_i = '0;
    logic [1:0]  space_i = 2'd1;
    logic        xlate_en_i = 1'b1;
    logic [63:0] ce_pri_i = '0, ce_sec_i = '0, ce_home_i = '0;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_valid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic        busy_o, done_o, wr_ok_o;
    logic [63:0] real_addr_o, exc_word_o;
    logic [2:0]  fault_o;

    int errs = 0, checks = 0;
    int nreq = 0;
    int lat = 1;
    logic [63:0] seen [8];
    logic [63:0] ta [24];
    logic [63:0] td [24];
    int tn = 0;

    logic        r_ok, r_wr;
    logic [63:0] r_real, r_exc;
    logic [2:0]  r_flt;

    localparam logic [63:0] PAT = 64'hA5C3_6E91_2B4D_7F58;

    always #5 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst(rst), .start(start), .vaddr_i(vaddr_i), .acc_i(acc_i),
        .space_i(space_i), .xlate_en_i(xlate_en_i), .ce_pri_i(ce_pri_i),
        .ce_sec_i(ce_sec_i), .ce_home_i(ce_home_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .real_addr_o(real_addr_o),
        .wr_ok_o(wr_ok_o), .fault_o(fault_o), .exc_word_o(exc_word_o)
    );

    function automatic logic [63:0] lookup(input logic [63:0] a);
        for (int i = 0; i < tn; i++) if (ta[i] == a) return td[i];
        return 64'h620;
    endfunction

    function automatic logic [63:0] boff(input logic [63:0] va, input int lv);
        return (va >> (17 + 11 * lv)) & 64'h3FF8;
    endfunction

    function automatic logic [63:0] poff(input logic [63:0] va);
        return (va >> 9) & 64'h7F8;
    endfunction

    function automatic logic [63:0] org_of(input int sp);
        return 64'h1000_0000 * 64'(sp);
    endfunction

    function automatic logic [63:0] frame_of(input int sp);
        return 64'h7_0000_0000 + (64'(sp) << 24);
    endfunction

    function automatic logic [63:0] ce_of(input int sp, input int t);
        return org_of(sp) | (64'(t) << 2);
    endfunction

    function automatic logic [63:0] lim(input int t);
        case (t)
            0: return 64'h0000_0000_7FFF_FFFF;
            1: return 64'h0000_03FF_FFFF_FFFF;
            2: return 64'h001F_FFFF_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [63:0] xw(input logic [63:0] va, input int code);
        return {va[63:12], 12'd0} | 64'(code);
    endfunction

    task automatic add(input logic [63:0] a, input logic [63:0] d);
        ta[tn] = a; td[tn] = d; tn++;
    endtask

    task automatic build(input int sp, input int t, input logic [63:0] va, input bit ro);
        logic [63:0] o, nxt;
        o = org_of(sp);
        for (int lv = t; lv >= 0; lv--) begin
            nxt = org_of(sp) + 64'h10_0000 * 64'(t - lv + 1);
            add(o + boff(va, lv), nxt | (64'(lv) << 2));
            o = nxt;
        end
        add(o + poff(va), frame_of(sp) | (ro ? 64'h200 : 64'h0));
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    // memory responder: answers each request after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_valid_i = 1'b0;
            if (mem_req_o) begin
                if (nreq < 8) seen[nreq] = mem_addr_o;
                nreq++;
                for (int i = 0; i < lat; i++) @(negedge clk);
                mem_rdata_i = lookup(mem_addr_o === 64'hx ? 64'h0 : seen[(nreq - 1) % 8]);
                mem_valid_i = 1'b1;
            end
        end
    end

    // called at a negedge; returns at the negedge where done is seen
    task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] sp,
                       input bit xon, input bit poke);
        int cyc;
        nreq = 0;
        vaddr_i = va; acc_i = acc; space_i = sp; xlate_en_i = xon;
        start = 1'b1;
        @(negedge clk);
        if (poke) begin
            eq("R11 busy after start", 64'(busy_o), 64'd1);
            start = 1'b1;
            vaddr_i = ~va;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        r_ok = done_o; r_real = real_addr_o; r_wr = wr_ok_o; r_flt = fault_o; r_exc = exc_word_o;
        chk(r_ok, "R11 done timeout", 64'(r_ok), 64'd1);
    endtask

    initial begin
        #1_500_000;
        errs++; checks++;
        $display("FAIL R11 watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [63:0] va;
        int eff;
        repeat (3) @(negedge clk);
        eq("R11 reset busy", 64'(busy_o), 64'd0);
        eq("R11 reset done", 64'(done_o), 64'd0);
        eq("R11 reset req", 64'(mem_req_o), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 translation disabled
        tn = 0;
        ce_pri_i = ce_of(1, 3); ce_sec_i = ce_of(2, 3); ce_home_i = ce_of(3, 3);
        run(64'hDEAD_BEEF_1234_5678, 2'd1, 2'd2, 1'b0, 1'b0);
        eq("R1 real", r_real, 64'hDEAD_BEEF_1234_5678);
        eq("R1 reads", 64'(nreq), 64'd0);
        eq("R1 fault", 64'(r_flt), 64'd0);
        eq("R1 wr_ok", 64'(r_wr), 64'd1);

        // R2 real-space control element
        ce_pri_i = ce_of(1, 3) | 64'h20;
        run(64'h0123_4567_89AB_CDEF, 2'd0, 2'd1, 1'b1, 1'b0);
        eq("R2 real", r_real, 64'h0123_4567_89AB_CDEF);
        eq("R2 reads", 64'(nreq), 64'd0);
        eq("R2 fault", 64'(r_flt), 64'd0);

        // R3 R4 R10 sweep over top type, space mode and access kind
        for (int t = 0; t < 4; t++) begin
            va = PAT & lim(t);
            tn = 0;
            for (int s = 1; s < 4; s++) build(s, t, va, 1'b0);
            ce_pri_i = ce_of(1, t); ce_sec_i = ce_of(2, t); ce_home_i = ce_of(3, t);
            for (int sp = 0; sp < 4; sp++) begin
                for (int acc = 0; acc < 3; acc++) begin
                    lat = 1 + (checks % 3);
                    run(va, 2'(acc), 2'(sp), 1'b1, 1'b0);
                    eff = (sp == 2 && acc == 2) ? 1 : (sp == 0 ? 1 : sp);
                    eq("R10 real via space", r_real, frame_of(eff) | {52'd0, va[11:0]});
                    eq("R3 read count", 64'(nreq), 64'(t + 2));
                    eq("R3 first address", seen[0], org_of(eff) + boff(va, t));
                    eq("R4 page address", seen[t + 1],
                       org_of(eff) + 64'h10_0000 * 64'(t + 1) + poff(va));
                    eq("R3 fault", 64'(r_flt), 64'd0);
                    eq("R3 wr_ok", 64'(r_wr), 64'd1);
                end
            end
        end
        lat = 2;

        // R5 R6 R12 faults at every upper level
        for (int k = 0; k < 2; k++) begin
            int t;
            t = (k == 0) ? 1 : 3;
            va = PAT & lim(t);
            ce_pri_i = ce_of(1, t);
            for (int pos = 0; pos <= t; pos++) begin
                tn = 0; build(1, t, va, 1'b0); td[pos] = td[pos] | 64'h20;
                run(va, 2'd0, 2'd1, 1'b1, 1'b0);
                eq("R5 invalid upper", 64'(r_flt), 64'd1);
                eq("R5 reads", 64'(nreq), 64'(pos + 1));
                eq("R9 exc primary", r_exc, xw(va, 1));
                tn = 0; build(1, t, va, 1'b0); td[pos] = td[pos] ^ 64'h4;
                run(va, 2'd0, 2'd1, 1'b1, 1'b0);
                eq("R6 type mismatch", 64'(r_flt), 64'd3);
                eq("R6 reads", 64'(nreq), 64'(pos + 1));
            end
            tn = 0; build(1, t, va, 1'b0); td[0] = (td[0] | 64'h20) ^ 64'h4;
            run(va, 2'd0, 2'd1, 1'b1, 1'b0);
            eq("R12 invalid over type", 64'(r_flt), 64'd1);
            tn = 0; build(1, t, va, 1'b0); td[t + 1] = td[t + 1] | 64'h400;
            run(va, 2'd0, 2'd1, 1'b1, 1'b0);
            eq("R5 invalid page", 64'(r_flt), 64'd2);
            eq("R5 page reads", 64'(nreq), 64'(t + 2));
            eq("R9 no real on fault", r_real, 64'd0);
        end

        // R8 read-only page
        va = PAT & lim(2);
        tn = 0; build(1, 2, va, 1'b1); ce_pri_i = ce_of(1, 2);
        run(va, 2'd0, 2'd1, 1'b1, 1'b0);
        eq("R8 ro read fault", 64'(r_flt), 64'd0);
        eq("R8 ro read wr_ok", 64'(r_wr), 64'd0);
        run(va, 2'd2, 2'd1, 1'b1, 1'b0);
        eq("R8 ro fetch wr_ok", 64'(r_wr), 64'd0);
        run(va, 2'd1, 2'd1, 1'b1, 1'b0);
        eq("R8 ro write fault", 64'(r_flt), 64'd4);
        eq("R9 prot exc", r_exc, xw(va, 5));
        td[3] = td[3] | 64'h400;
        run(va, 2'd1, 2'd1, 1'b1, 1'b0);
        eq("R12 page invalid over prot", 64'(r_flt), 64'd2);

        // R9 R10 space codes in the exception word
        tn = 0;
        for (int s = 1; s < 4; s++) build(s, 2, va, 1'b0);
        td[3] = td[3] | 64'h400; td[7] = td[7] | 64'h400; td[11] = td[11] | 64'h400;
        ce_pri_i = ce_of(1, 2); ce_sec_i = ce_of(2, 2); ce_home_i = ce_of(3, 2);
        run(va, 2'd0, 2'd2, 1'b1, 1'b0);
        eq("R9 secondary code", r_exc, xw(va, 2));
        run(va, 2'd0, 2'd3, 1'b1, 1'b0);
        eq("R9 home code", r_exc, xw(va, 3));
        run(va, 2'd2, 2'd2, 1'b1, 1'b0);
        eq("R10 secondary fetch code", r_exc, xw(va, 1));

        // R7 address range per top type
        for (int t = 0; t < 3; t++) begin
            va = (PAT & lim(t)) | (lim(t) + 64'd1);
            ce_pri_i = ce_of(1, t);
            run(va, 2'd0, 2'd1, 1'b1, 1'b0);
            eq("R7 range fault", 64'(r_flt), 64'd3);
            eq("R7 no reads", 64'(nreq), 64'd0);
            eq("R7 exc", r_exc, xw(va, 1));
        end
        va = 64'hFFFF_FFFF_FFFF_F123;
        tn = 0; build(1, 3, va, 1'b0); ce_pri_i = ce_of(1, 3);
        run(va, 2'd0, 2'd1, 1'b1, 1'b0);
        eq("R7 top type unlimited", 64'(r_flt), 64'd0);
        eq("R7 top type real", r_real, frame_of(1) | 64'h123);

        // R11 start while busy is ignored
        va = PAT;
        tn = 0; build(1, 3, va, 1'b0);
        lat = 3;
        run(va, 2'd0, 2'd1, 1'b1, 1'b1);
        eq("R11 poke real", r_real, frame_of(1) | {52'd0, va[11:0]});
        eq("R11 poke reads", 64'(nreq), 64'd5);
        @(negedge clk);
        eq("R11 done one cycle", 64'(done_o), 64'd0);
        eq("R11 idle after", 64'(busy_o), 64'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule